// File: doc/BRIEF.md
# UART register block with receive buffer and transmit holder

This block is the register face of a UART as seen from an APB slave port. Software reaches three live locations: a data register, a read-only status word and a 32-bit control word. A fourth location, the rate scaler, reads as zero and ignores writes. Bytes arrive on a valid/ready byte-stream input and are stored in a receive buffer, which software drains by reading the data register. Bytes written to the data register leave on a valid/ready byte-stream output. Serial bit timing, the baud scaler and parity generation are handled elsewhere.

The receive buffer is flushed on drain. Its write index only moves forward while bytes remain unread. Once the last unread byte is taken, both indexes return to zero. The transmit side holds one byte. A data write that arrives while that byte is still waiting stalls the bus access until the byte is taken. A single interrupt line pulses for one cycle after each stored receive byte and after each launched transmit byte, when the matching enable is set.

Top module: `uart_regif`

## Requirements
- R1: After reset the control word reads 0 and the status word reads 0x0000_0006, with bit 1 (transmit shift empty) and bit 2 (transmit holder empty) set and every other bit clear.
- R2: A write to offset 0x08 stores all 32 bits of the control word, and a read returns them unchanged. Writes to offset 0x04 (status) have no effect on the status value.
- R3: Offset 0x0C and every offset other than 0x00, 0x03, 0x04 and 0x08 read as zero, and writes to them change nothing. Only address bits [4:0] are decoded, so offset 0x24 reads the status word. PSLVERR is always low.
- R4: An input byte is stored only while control bit 0 (receive enable) is set. While that bit is clear, the handshake still completes and the byte is discarded.
- R5: A read at offset 0x00 or 0x03 returns the oldest unread byte in bits [7:0] (upper bits zero) and removes it. A read with nothing unread returns zero and changes no state.
- R6: Status bit 0 (data ready) is set while at least one byte is unread and clears when the last one is read.
- R7: Storage is released only when the buffer drains completely. With RX_DEPTH bytes stored, rx_ready is low and status bit 10 is set, even after some of those bytes are read. Status bit 8 is set while at least RX_DEPTH/2 bytes are unread.
- R8: A write to offset 0x00 or 0x03 with control bit 1 (transmit enable) set presents pwdata[7:0] on tx_data with tx_valid high, held stable until tx_ready. With bit 1 clear, the write is dropped.
- R9: While a transmit byte is held, status bits 1 and 2 are clear and bit 9 is set. An enabled data write during that time keeps PREADY low until the held byte has been taken.
- R10: irq is high for exactly the one cycle after a byte is stored when control bit 2 is set, and the one cycle after a transmit byte is loaded when control bit 3 is set. It stays low for the same events when those bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| prst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address; bits [4:0] decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Access complete; low while a data write waits for the transmit holder |
| pslverr | output | 1 | Always low |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with RX_DEPTH set to 4 and ADDR_W left at 12. The small depth means four input bytes are enough to fill the buffer, raise the full and half flags, and drop rx_ready. A partial read then shows that space is not released until the buffer drains completely. The 12-bit address leaves room for offset 0x24, which shows that the upper address bits are ignored. Holding tx_ready low lets the bench observe a stalled data write and the transmit status bits during the stall.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  // Decoded register offsets (address bits [4:0])
  localparam logic [4:0] OFF_DATA   = 5'h00;
  localparam logic [4:0] OFF_DATA_B = 5'h03;
  localparam logic [4:0] OFF_STAT   = 5'h04;
  localparam logic [4:0] OFF_CTRL   = 5'h08;
  localparam logic [4:0] OFF_SCAL   = 5'h0C;

  // Control word bit positions
  localparam int C_RXEN = 0;
  localparam int C_TXEN = 1;
  localparam int C_RXIE = 2;
  localparam int C_TXIE = 3;

  // Status word bit positions
  localparam int S_DREADY = 0;
  localparam int S_TSHIFT = 1;
  localparam int S_TEMPTY = 2;
  localparam int S_RXHALF = 8;
  localparam int S_TXFULL = 9;
  localparam int S_RXFULL = 10;

  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty,
  output logic         full,
  output logic         half
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] fill_q, rd_q;
  logic [CW-1:0] fill_n, rd_n, unread;
  logic          do_push, do_pop;

  assign do_push = push && (fill_q != FULL_CNT);
  assign do_pop  = pop && (rd_q != fill_q);

  always_comb begin
    fill_n = fill_q + CW'(do_push);
    rd_n   = rd_q + CW'(do_pop);
    if (rd_n == fill_n) begin
      fill_n = '0;
      rd_n   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      rd_q   <= '0;
    end else begin
      fill_q <= fill_n;
      rd_q   <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[fill_q[IW-1:0]] <= din;
  end

  assign unread   = fill_q - rd_q;
  assign nonempty = (rd_q != fill_q);
  assign full     = (fill_q == FULL_CNT);
  assign half     = (unread >= HALF_CNT);
  assign dout     = nonempty ? mem[rd_q[IW-1:0]] : '0;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R7
  AST_RD_BEHIND: assert property (@(posedge clk) disable iff (rst) rd_q <= fill_q); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst) (pop && !nonempty && !push) |=> !nonempty); // R5
endmodule

// File: rtl/uart_tx_holder.sv
module uart_tx_holder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] tx_data,
  output logic         tx_valid,
  input  logic         tx_ready
);
  logic [W-1:0] data_q;
  logic         valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= din;
    end else if (valid_q && tx_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign busy     = valid_q;
  assign tx_valid = valid_q;
  assign tx_data  = data_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst) (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst) load |-> !tx_valid); // R9
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RX_DEPTH = 16
) (
  input  logic              pclk,
  input  logic              prst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              irq
);
  logic [4:0]        off;
  logic              acc, is_data, tx_go, tx_load, pop, ctrl_wr;
  logic              rx_accept, rx_store;
  logic [BUS_W-1:0]  ctrl_q, status;
  logic [BYTE_W-1:0] rx_dout;
  logic              rx_nonempty, rx_full, rx_half, tx_busy;
  logic              irq_q;
  logic              unused_addr;

  assign off         = paddr[4:0];
  assign unused_addr = ^paddr;
  assign acc         = psel && penable;
  assign is_data     = (off == OFF_DATA) || (off == OFF_DATA_B);
  assign tx_go       = acc && pwrite && is_data && ctrl_q[C_TXEN];
  assign tx_load     = tx_go && !tx_busy;
  assign pop         = acc && !pwrite && is_data;
  assign ctrl_wr     = acc && pwrite && (off == OFF_CTRL);
  assign rx_ready    = !rx_full;
  assign rx_accept   = rx_valid && rx_ready;
  assign rx_store    = rx_accept && ctrl_q[C_RXEN];

  uart_rx_buffer #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rxbuf (
    .clk(pclk), .rst(prst), .push(rx_store), .din(rx_data), .pop(pop),
    .dout(rx_dout), .nonempty(rx_nonempty), .full(rx_full), .half(rx_half)
  );

  uart_tx_holder #(.W(BYTE_W)) u_txh (
    .clk(pclk), .rst(prst), .load(tx_load), .din(pwdata[BYTE_W-1:0]),
    .busy(tx_busy), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  always_ff @(posedge pclk) begin
    if (prst) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= pwdata;
  end

  always_ff @(posedge pclk) begin
    if (prst) irq_q <= 1'b0;
    else irq_q <= (rx_store && ctrl_q[C_RXIE]) || (tx_load && ctrl_q[C_TXIE]);
  end
  assign irq = irq_q;

  always_comb begin
    status           = '0;
    status[S_DREADY] = rx_nonempty;
    status[S_TSHIFT] = !tx_busy;
    status[S_TEMPTY] = !tx_busy;
    status[S_RXHALF] = rx_half;
    status[S_TXFULL] = tx_busy;
    status[S_RXFULL] = rx_full;
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (off)
        OFF_DATA, OFF_DATA_B: prdata = {{(BUS_W-BYTE_W){1'b0}}, rx_dout};
        OFF_STAT:             prdata = status;
        OFF_CTRL:             prdata = ctrl_q;
        OFF_SCAL:             prdata = '0;
        default:              prdata = '0;
      endcase
    end
  end

  assign pready  = !(tx_go && tx_busy);
  assign pslverr = 1'b0;

  AST_STALL_PENDING: assert property (@(posedge pclk) disable iff (prst) (psel && penable && !pready) |-> tx_valid); // R9
  AST_IRQ_CAUSE: assert property (@(posedge pclk) disable iff (prst) irq |-> $past(rx_valid || (psel && penable && pwrite))); // R10
  AST_NO_ERR: assert property (@(posedge pclk) disable iff (prst) psel |-> !pslverr); // R3
endmodule

// File: tb/test_uart_regif.sv
module test_uart_regif;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [7:0] rx_data = '0;
  logic rx_valid = 0, rx_ready;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready = 0, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif #(.ADDR_W(ADDR_W), .RX_DEPTH(DEPTH)) i_uart_regif (
    .pclk(clk), .prst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, output int waits);
    waits = 0;
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; #1;
    while (!pready) begin waits++; @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1;
    d = prdata;
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    apb_read(12'h008, d); chk("R1 ctrl", d, 32'h0);
    apb_read(12'h004, d); chk("R1 status", d, 32'h6);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R3 pslverr", {31'b0, pslverr}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d; int w;
    apb_write(12'h008, 32'hA5A0_1230, w);
    apb_read(12'h008, d); chk("R2 ctrl readback", d, 32'hA5A0_1230);
    apb_write(12'h008, 32'h0, w);
    apb_write(12'h004, 32'hFFFF_FFFF, w);
    apb_read(12'h004, d); chk("R2 status ignores write", d, 32'h6);
    apb_write(12'h00C, 32'h55, w);
    apb_read(12'h00C, d); chk("R3 scaler zero", d, 32'h0);
    apb_read(12'h010, d); chk("R3 other offset zero", d, 32'h0);
    apb_read(12'h024, d); chk("R3 alias status", d, 32'h6);
    apb_read(12'h008, d); chk("R3 ctrl untouched", d, 32'h0);
  endtask

  task automatic t_rx_disabled;
    logic [31:0] d;
    rx_send(8'h11);
    apb_read(12'h004, d); chk("R4 byte discarded", d, 32'h6);
    apb_read(12'h000, d); chk("R5 empty read zero", d, 32'h0);
  endtask

  task automatic t_rx_order;
    logic [31:0] d; int w;
    apb_write(12'h008, 32'h1, w);
    rx_send(8'h41); rx_send(8'h42); rx_send(8'h43);
    apb_read(12'h004, d); chk("R6 R7 ready and half", d, 32'h107);
    apb_read(12'h000, d); chk("R5 first", d, 32'h41);
    apb_read(12'h003, d); chk("R5 second at offset 3", d, 32'h42);
    apb_read(12'h000, d); chk("R5 third", d, 32'h43);
    apb_read(12'h004, d); chk("R6 ready clears", d, 32'h6);
    apb_read(12'h000, d); chk("R5 empty after drain", d, 32'h0);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    rx_send(8'hA0); rx_send(8'hA1); rx_send(8'hA2); rx_send(8'hA3);
    chk("R7 ready low when full", {31'b0, rx_ready}, 32'h0);
    apb_read(12'h004, d); chk("R7 full status", d, 32'h507);
    apb_read(12'h000, d); chk("R5 full pop", d, 32'hA0);
    chk("R7 no space before drain", {31'b0, rx_ready}, 32'h0);
    apb_read(12'h004, d); chk("R7 still full", d, 32'h507);
    apb_read(12'h000, d); chk("R5 pop A1", d, 32'hA1);
    apb_read(12'h000, d); chk("R5 pop A2", d, 32'hA2);
    apb_read(12'h000, d); chk("R5 pop A3", d, 32'hA3);
    chk("R7 ready after drain", {31'b0, rx_ready}, 32'h1);
    apb_read(12'h004, d); chk("R7 flushed status", d, 32'h6);
  endtask

  task automatic t_tx;
    logic [31:0] d; int w;
    apb_write(12'h000, 32'h99, w);
    chk("R8 disabled write dropped", {31'b0, tx_valid}, 32'h0);
    apb_write(12'h008, 32'h2, w);
    apb_write(12'h000, 32'h1234_56C3, w);
    chk("R9 first write no stall", w, 0);
    chk("R8 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R8 tx_data low byte", {24'b0, tx_data}, 32'hC3);
    apb_read(12'h004, d); chk("R9 busy status", d, 32'h200);
    fork
      apb_write(12'h003, 32'h77, w);
      begin repeat (4) @(negedge clk); tx_ready = 1; @(negedge clk); tx_ready = 0; end
    join
    chk("R9 stalled write", {31'b0, (w >= 1)}, 32'h1);
    chk("R8 second byte", {24'b0, tx_data}, 32'h77);
    @(negedge clk); tx_ready = 1; @(negedge clk); tx_ready = 0;
    chk("R8 drained", {31'b0, tx_valid}, 32'h0);
    apb_read(12'h004, d); chk("R9 idle status", d, 32'h6);
  endtask

  task automatic t_irq;
    logic [31:0] d; int w;
    apb_write(12'h008, 32'h5, w);
    rx_send(8'h5A);
    chk("R10 rx pulse", {31'b0, irq}, 32'h1);
    @(negedge clk); chk("R10 rx pulse one cycle", {31'b0, irq}, 32'h0);
    apb_read(12'h000, d);
    apb_write(12'h008, 32'hA, w);
    apb_write(12'h000, 32'h3C, w);
    chk("R10 tx pulse", {31'b0, irq}, 32'h1);
    @(negedge clk); chk("R10 tx pulse one cycle", {31'b0, irq}, 32'h0);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    apb_write(12'h008, 32'h3, w);
    rx_send(8'h66);
    chk("R10 no rx pulse when off", {31'b0, irq}, 32'h0);
    apb_write(12'h000, 32'h12, w);
    chk("R10 no tx pulse when off", {31'b0, irq}, 32'h0);
    apb_read(12'h000, d); chk("R4 enabled byte stored", d, 32'h66);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_regs();
    t_rx_disabled();
    t_rx_order();
    t_flush();
    t_tx();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule